// File: doc/BRIEF.md
# Root-Hub Host Controller Register Block

This block holds the I/O-mapped operational registers of a two-port USB 1.x host controller. It decodes an access on a simple request interface into a 20-byte window that starts at a programmable base address. Each register has its own legal access width. The block keeps the run/configuration word, the cause flags, the cause enables, the frame counter, the frame-list pointer, the start-of-frame trim value and one status/control word per root port.

The cause flags are cleared by writing one to them. An access that breaks a rule sets a sticky error output: a wrong width, a reserved bit written as one, or a read-only port bit written as one. The write still lands, with the offending bits dropped. A 1 ms tick input advances the frame counter while the controller is running. The interrupt output combines the cause flags with their enables.

Reads return data combinationally on the same cycle as the request. Writes take effect at the next clock edge.

Top module: `hc_regfile`

## Requirements
- R1: The block responds only when `acc_addr - io_base` is in 0x00..0x13 and `acc_addr >= io_base`. Outside that window, reads return 0, writes change nothing, and no error is raised. Inside the window the offsets are: 0x00 command, 0x02 status, 0x04 enable, 0x06 frame number, 0x08 frame base, 0x0C SOF trim, 0x10 port 0, 0x12 port 1. Other offsets read 0 and ignore writes.
- R2: After reset every register reads 0, except port bit 0, which shows the connect input. `err_o` and `irq_o` are both 0.
- R3: The legal lengths (`acc_len`, in bytes) are as follows. Offsets 0x00, 0x02, 0x04 and 0x06 take 2. Offset 0x08 takes 4 and 0x0C takes 1. Offsets 0x10 and 0x12 accept reads of 1 or 2 and writes of 2. Offsets 0x11 and 0x13 accept only 1-byte reads. Any other length inside the window on these offsets sets `err_o`.
- R4: The command register stores bits 7:0; bit 0 is run. Setting any of bits 15:8 sets `err_o`, and those bits are dropped.
- R5: The status register has flags at bit 0 (transfer interrupt), bit 3 (bus error), bit 4 (controller error) and bit 5 (halted). `cause_set[0]`, `[1]`, `[2]` and `[3]` set them in that order. Writing 1 to a flag clears it and writing 0 leaves it alone. A set and a clear in the same cycle leave the flag set. Setting any of bits 15:6 sets `err_o`.
- R6: The enable register stores bits 3:0: bit 0 timeout/CRC, bit 1 resume, bit 2 completion, bit 3 short packet. Setting any of bits 15:4 sets `err_o`.
- R7: `irq_o` = (status[0] AND (enable[2] OR enable[3])) OR ((status[3] OR status[4]) AND enable[0]).
- R8: The frame number occupies bits 10:0 and is loaded by a write. On a cycle with `frame_tick` high, run set and no frame-number write, it increments modulo 2048. Setting any of bits 15:11 on a write sets `err_o`.
- R9: The frame base stores bits 31:12 and reads bits 11:0 as 0. Setting any of bits 11:0 on a write sets `err_o`.
- R10: The SOF trim register stores bits 6:0. Setting bit 7 sets `err_o`.
- R11: The port register at offset `off` is port `(off & 0xF) >> 1`. Its word holds suspend at bit 12 and reset at bit 9, both writable. Bit 0 is the read-only connect input. Bits 5 and 4 are read-only zero, and all other bits read 0. Writing 1 to bit 5, 4 or 0 sets `err_o`.
- R12: A 1-byte read at offset 0x11 or 0x13 returns bits 15:8 of that port word in `acc_rdata[7:0]`. A write to those offsets sets `err_o` and changes nothing.
- R13: `err_o` stays set until reset, and a rule-breaking write still updates the legal bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_base | input | ADDR_W | Base address of the register window |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Absolute I/O address |
| acc_len | input | 3 | Access length in bytes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, same cycle |
| frame_tick | input | 1 | 1 ms frame pulse |
| cause_set | input | 4 | Status flag set pulses |
| port_conn | input | NPORTS | Connect state per port |
| irq_o | output | 1 | Interrupt request |
| err_o | output | 1 | Sticky access-rule error |

## Verification
The bench builds the block with its defaults: a 16-bit address, two ports and an 11-bit frame counter. With these values both port slots and the high-byte offsets fall inside the window. The counter wraps from 0x7FF to 0 after one directed load and a single tick. The base address is moved to a second value in mid-run, which exercises the subtracting decode at a base other than the one set at reset.

// File: rtl/hc_pkg.sv
package hc_pkg;

   typedef enum logic [3:0] {
      RID_NONE, RID_CMD, RID_STS, RID_IE, RID_FNUM,
      RID_FBASE, RID_SOF, RID_PORT, RID_PORT_HI
   } reg_id_e;

   localparam int PORT_OFF = 16;   // first port slot offset

   // bits that must be written as zero
   localparam logic [31:0] RSV_CMD   = 32'h0000_FF00;
   localparam logic [31:0] RSV_STS   = 32'h0000_FFC0;
   localparam logic [31:0] RSV_IE    = 32'h0000_FFF0;
   localparam logic [31:0] RSV_FBASE = 32'h0000_0FFF;
   localparam logic [31:0] RSV_SOF   = 32'h0000_0080;
   localparam logic [31:0] RO_PORT   = 32'h0000_0031;

   // clearable status flags
   localparam logic [5:0] STS_W1C = 6'b111001;

endpackage

// File: rtl/hc_decode.sv
module hc_decode
   import hc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NPORTS = 2,
   parameter int PIDX_W = 1
) (
   input  logic              acc_valid,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [ADDR_W-1:0] io_base,
   input  logic [2:0]        acc_len,
   output logic              hit,
   output reg_id_e           id,
   output logic [PIDX_W-1:0] pidx,
   output logic              len_ok
);
   localparam int WIN = PORT_OFF + 2 * NPORTS;

   logic [ADDR_W-1:0] off;
   logic [4:0]        off5;

   assign off  = acc_addr - io_base;
   assign off5 = off[4:0];
   assign hit  = acc_valid && (acc_addr >= io_base) && (off < ADDR_W'(WIN));
   // port slot: (offset & 0xF) >> 1
   assign pidx = PIDX_W'(off5[3:1]);

   always_comb begin
      id = RID_NONE;
      if (off5 >= 5'(PORT_OFF)) begin
         id = off5[0] ? RID_PORT_HI : RID_PORT;
      end else begin
         case (off5)
            5'h00:   id = RID_CMD;
            5'h02:   id = RID_STS;
            5'h04:   id = RID_IE;
            5'h06:   id = RID_FNUM;
            5'h08:   id = RID_FBASE;
            5'h0C:   id = RID_SOF;
            default: id = RID_NONE;
         endcase
      end
   end

   always_comb begin
      case (id)
         RID_CMD, RID_STS, RID_IE, RID_FNUM: len_ok = (acc_len == 3'd2);
         RID_FBASE:   len_ok = (acc_len == 3'd4);
         RID_SOF:     len_ok = (acc_len == 3'd1);
         RID_PORT:    len_ok = acc_we ? (acc_len == 3'd2)
                                      : (acc_len == 3'd1 || acc_len == 3'd2);
         RID_PORT_HI: len_ok = !acc_we && (acc_len == 3'd1);
         default:     len_ok = 1'b1;
      endcase
   end

endmodule

// File: rtl/hc_port.sv
module hc_port (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic        suspend_in,
   input  logic        reset_in,
   input  logic        conn,
   output logic [15:0] word
);
   logic suspend_q, reset_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         suspend_q <= 1'b0;
         reset_q   <= 1'b0;
      end else if (wr) begin
         suspend_q <= suspend_in;
         reset_q   <= reset_in;
      end
   end

   assign word = {3'b000, suspend_q, 2'b00, reset_q, 8'h00, conn};

endmodule

// File: rtl/hc_frame.sv
module hc_frame #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wval,
   input  logic         tick,
   input  logic         run,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (wr)          cnt <= wval;
      else if (tick && run) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/hc_regfile.sv
module hc_regfile
   import hc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NPORTS = 2,
   parameter int FNUM_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_base,
   input  logic              acc_valid,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [2:0]        acc_len,
   input  logic [31:0]       acc_wdata,
   output logic [31:0]       acc_rdata,
   input  logic              frame_tick,
   input  logic [3:0]        cause_set,
   input  logic [NPORTS-1:0] port_conn,
   output logic              irq_o,
   output logic              err_o
);
   localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
   localparam logic [15:0] FN_RSV = 16'(16'hFFFF << FNUM_W);

   if (NPORTS < 1 || NPORTS > 2) begin : g_bad_ports
      $error("hc_regfile: NPORTS must be 1 or 2");
   end
   if (FNUM_W < 4 || FNUM_W > 11) begin : g_bad_fnum
      $error("hc_regfile: FNUM_W must be 4..11");
   end
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("hc_regfile: ADDR_W must be 5..32");
   end

   logic              acc_hit, len_ok;
   reg_id_e           id;
   logic [PIDX_W-1:0] pidx;

   hc_decode #(.ADDR_W(ADDR_W), .NPORTS(NPORTS), .PIDX_W(PIDX_W)) u_dec (
      .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr),
      .io_base(io_base), .acc_len(acc_len), .hit(acc_hit), .id(id),
      .pidx(pidx), .len_ok(len_ok)
   );

   logic        wr;
   logic [31:0] rsv;
   logic        bad;
   assign wr = acc_hit && acc_we;

   always_comb begin
      case (id)
         RID_CMD:   rsv = RSV_CMD;
         RID_STS:   rsv = RSV_STS;
         RID_IE:    rsv = RSV_IE;
         RID_FNUM:  rsv = {16'h0000, FN_RSV};
         RID_FBASE: rsv = RSV_FBASE;
         RID_SOF:   rsv = RSV_SOF;
         RID_PORT:  rsv = RO_PORT;
         default:   rsv = '0;
      endcase
   end

   assign bad = acc_hit && (!len_ok || (acc_we && |(acc_wdata & rsv)));

   always_ff @(posedge clk) begin
      if (!rst_n)   err_o <= 1'b0;
      else if (bad) err_o <= 1'b1;
   end

   // plain storage registers
   logic [7:0]  cmd_q;
   logic [3:0]  ie_q;
   logic [19:0] fb_q;
   logic [6:0]  sof_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         ie_q  <= '0;
         fb_q  <= '0;
         sof_q <= '0;
      end else if (wr) begin
         if (id == RID_CMD)   cmd_q <= acc_wdata[7:0];
         if (id == RID_IE)    ie_q  <= acc_wdata[3:0];
         if (id == RID_FBASE) fb_q  <= acc_wdata[31:12];
         if (id == RID_SOF)   sof_q <= acc_wdata[6:0];
      end
   end

   // status flags: set by causes, cleared by writing ones
   logic [5:0] sts_q, sts_clr, sts_set;
   logic       sts_wr;
   assign sts_wr  = wr && (id == RID_STS);
   assign sts_clr = sts_wr ? (acc_wdata[5:0] & STS_W1C) : 6'b0;
   assign sts_set = {cause_set[3], cause_set[2], cause_set[1], 2'b00, cause_set[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~sts_clr) | sts_set;
   end

   // frame counter
   logic              fn_wr;
   logic [FNUM_W-1:0] fn_cnt;
   assign fn_wr = wr && (id == RID_FNUM);

   hc_frame #(.W(FNUM_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .wr(fn_wr), .wval(acc_wdata[FNUM_W-1:0]),
      .tick(frame_tick), .run(cmd_q[0]), .cnt(fn_cnt)
   );

   // root ports
   logic [15:0] port_word [NPORTS];

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      hc_port u_port (
         .clk(clk), .rst_n(rst_n),
         .wr(wr && (id == RID_PORT) && (pidx == PIDX_W'(i))),
         .suspend_in(acc_wdata[12]), .reset_in(acc_wdata[9]),
         .conn(port_conn[i]), .word(port_word[i])
      );
   end

   // read path
   logic [31:0] rd;
   always_comb begin
      case (id)
         RID_CMD:     rd = {24'h0, cmd_q};
         RID_STS:     rd = {26'h0, sts_q};
         RID_IE:      rd = {28'h0, ie_q};
         RID_FNUM:    rd = 32'(fn_cnt);
         RID_FBASE:   rd = {fb_q, 12'h000};
         RID_SOF:     rd = {25'h0, sof_q};
         RID_PORT:    rd = {16'h0, port_word[pidx]};
         RID_PORT_HI: rd = {24'h0, port_word[pidx][15:8]};
         default:     rd = '0;
      endcase
   end

   assign acc_rdata = (acc_hit && !acc_we) ? rd : '0;

   assign irq_o = (sts_q[0] && (ie_q[2] || ie_q[3]))
               || ((sts_q[3] || sts_q[4]) && ie_q[0]);

endmodule

// File: rtl/hc_regfile_chk.sv
module hc_regfile_chk #(
   parameter int FNUM_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              err_o,
   input logic              irq_o,
   input logic              frame_tick,
   input logic              run,
   input logic              fnum_wr,
   input logic [FNUM_W-1:0] fnum,
   input logic [5:0]        sts,
   input logic              sts_wr,
   input logic              wbit0,
   input logic              cause0,
   input logic              hit,
   input logic [7:0]        cmd
);
   // R13
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R8
   fnum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && run && !fnum_wr) |=> (fnum == FNUM_W'($past(fnum) + 1'b1)));

   // R8
   fnum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_tick && !fnum_wr) |=> $stable(fnum));

   // R7
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts[0] && !sts[3] && !sts[4]) |-> !irq_o);

   // R5
   sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && wbit0 && !cause0) |=> !sts[0]);

   // R1
   miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(cmd));
endmodule

bind hc_regfile hc_regfile_chk #(.FNUM_W(FNUM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .err_o(err_o), .irq_o(irq_o),
   .frame_tick(frame_tick), .run(cmd_q[0]), .fnum_wr(fn_wr), .fnum(fn_cnt),
   .sts(sts_q), .sts_wr(sts_wr), .wbit0(acc_wdata[0]), .cause0(cause_set[0]),
   .hit(acc_hit), .cmd(cmd_q)
);

// File: tb/hc_regfile_tb.sv
module hc_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] io_base;
   logic        acc_valid, acc_we;
   logic [15:0] acc_addr;
   logic [2:0]  acc_len;
   logic [31:0] acc_wdata, acc_rdata;
   logic        frame_tick;
   logic [3:0]  cause_set;
   logic [1:0]  port_conn;
   logic        irq_o, err_o;

   always #5 clk = ~clk;

   hc_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .io_base(io_base), .acc_valid(acc_valid),
      .acc_we(acc_we), .acc_addr(acc_addr), .acc_len(acc_len),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .frame_tick(frame_tick),
      .cause_set(cause_set), .port_conn(port_conn), .irq_o(irq_o), .err_o(err_o)
   );

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   logic [7:0]  m_cmd;
   logic [5:0]  m_st;
   logic [3:0]  m_ie;
   logic [10:0] m_fn;
   logic [19:0] m_fb;
   logic [6:0]  m_sof;
   logic [1:0]  m_su, m_pr;
   logic        m_err;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic bit legal(int off, int len, bit we);
      case (off)
         0, 2, 4, 6: return len == 2;
         8:          return len == 4;
         12:         return len == 1;
         16, 18:     return we ? (len == 2) : (len == 1 || len == 2);
         17, 19:     return !we && len == 1;
         default:    return 1'b1;
      endcase
   endfunction

   function automatic logic [31:0] rsvm(int off);
      case (off)
         0:       return 32'hFF00;
         2:       return 32'hFFC0;
         4:       return 32'hFFF0;
         6:       return 32'hF800;
         8:       return 32'h0FFF;
         12:      return 32'h0080;
         16, 18:  return 32'h0031;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] pword(int p);
      return {19'b0, m_su[p], 2'b00, m_pr[p], 8'h00, port_conn[p]};
   endfunction

   function automatic logic [31:0] mread(int off);
      case (off)
         0:       return {24'h0, m_cmd};
         2:       return {26'h0, m_st};
         4:       return {28'h0, m_ie};
         6:       return {21'h0, m_fn};
         8:       return {m_fb, 12'h0};
         12:      return {25'h0, m_sof};
         16:      return pword(0);
         18:      return pword(1);
         17:      return pword(0) >> 8;
         19:      return pword(1) >> 8;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic m_irq();
      return (m_st[0] && (m_ie[2] || m_ie[3])) || ((m_st[3] || m_st[4]) && m_ie[0]);
   endfunction

   function automatic string tg(int off);
      case (off)
         0: return "R4";   2: return "R5";   4: return "R6";   6: return "R8";
         8: return "R9";   12: return "R10"; 16, 18: return "R11";
         17, 19: return "R12";
         default: return "R1";
      endcase
   endfunction

   task automatic clear_model();
      m_cmd = '0; m_st = '0; m_ie = '0; m_fn = '0; m_fb = '0; m_sof = '0;
      m_su = '0; m_pr = '0; m_err = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acc_valid = 1'b0; frame_tick = 1'b0; cause_set = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      clear_model();
   endtask

   // one access cycle; checks read data, then err_o and irq_o after the edge
   task automatic acc(input logic [15:0] addr, input bit we, input int len,
                      input logic [31:0] wd, input bit tick, input logic [3:0] ev,
                      input string tag);
      int off;
      bit hit, wr;
      logic [31:0] exp;
      logic [5:0] w1c, evb;
      @(negedge clk);
      acc_valid = 1'b1; acc_we = we; acc_addr = addr; acc_len = 3'(len);
      acc_wdata = wd; frame_tick = tick; cause_set = ev;
      off = int'(addr) - int'(io_base);
      hit = (off >= 0) && (off < 20);
      exp = (hit && !we) ? mread(off) : 32'h0;
      #2;
      check(tag, acc_rdata, exp);
      @(posedge clk);
      wr  = hit && we;
      evb = {ev[3], ev[2], ev[1], 2'b00, ev[0]};
      w1c = (wr && off == 2) ? (wd[5:0] & 6'h39) : 6'h0;
      if (hit && (!legal(off, len, we) || (we && |(wd & rsvm(off))))) m_err = 1'b1;
      if (wr && off == 6)          m_fn = wd[10:0];
      else if (tick && m_cmd[0])   m_fn = m_fn + 11'd1;
      m_st = (m_st & ~w1c) | evb;
      if (wr) begin
         case (off)
            0:  m_cmd = wd[7:0];
            4:  m_ie  = wd[3:0];
            8:  m_fb  = wd[31:12];
            12: m_sof = wd[6:0];
            16: begin m_su[0] = wd[12]; m_pr[0] = wd[9]; end
            18: begin m_su[1] = wd[12]; m_pr[1] = wd[9]; end
            default: ;
         endcase
      end
      #1;
      acc_valid = 1'b0; frame_tick = 1'b0; cause_set = '0;
      check("R13", {31'b0, err_o}, {31'b0, m_err});
      check("R7",  {31'b0, irq_o}, {31'b0, m_irq()});
   endtask

   task automatic rd(input int off, input int len, input string tag);
      acc(io_base + 16'(off), 1'b0, len, 32'h0, 1'b0, 4'h0, tag);
   endtask

   task automatic wrr(input int off, input int len, input logic [31:0] wd, input string tag);
      acc(io_base + 16'(off), 1'b1, len, wd, 1'b0, 4'h0, tag);
   endtask

   task automatic idle(input bit tick, input logic [3:0] ev);
      acc(16'h0000, 1'b0, 2, 32'h0, tick, ev, "R1");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int lens [4] = '{1, 2, 4, 3};
      void'($urandom(32'd1234));
      io_base = 16'hFF40; port_conn = 2'b00;
      acc_we = 1'b0; acc_addr = '0; acc_len = '0; acc_wdata = '0;
      rst_n = 1'b0; acc_valid = 1'b0; frame_tick = 1'b0; cause_set = '0;
      do_reset();

      // R2 reset values
      rd(0, 2, "R2"); rd(2, 2, "R2"); rd(4, 2, "R2"); rd(6, 2, "R2");
      rd(8, 4, "R2"); rd(12, 1, "R2"); rd(16, 2, "R2"); rd(18, 2, "R2");

      // R11 connect input visible
      port_conn = 2'b10;
      rd(18, 2, "R11"); rd(16, 2, "R11");

      // R8 frame counting
      wrr(0, 2, 32'h0001, "R4");
      idle(1'b1, 4'h0); idle(1'b1, 4'h0); idle(1'b1, 4'h0);
      rd(6, 2, "R8");
      wrr(0, 2, 32'h0000, "R4");
      idle(1'b1, 4'h0);
      rd(6, 2, "R8");
      wrr(6, 2, 32'h07FF, "R8");
      wrr(0, 2, 32'h00E1, "R4");
      idle(1'b1, 4'h0);
      rd(6, 2, "R8");
      rd(0, 2, "R4");

      // R5 / R7 flags and interrupt
      wrr(4, 2, 32'h0004, "R6");
      idle(1'b0, 4'b0001);
      rd(2, 2, "R5");
      wrr(2, 2, 32'h0001, "R5");
      rd(2, 2, "R5");
      acc(io_base + 16'd2, 1'b1, 2, 32'h0001, 1'b0, 4'b0001, "R5");
      rd(2, 2, "R5");
      idle(1'b0, 4'b1110);
      rd(2, 2, "R5");
      wrr(4, 2, 32'h0001, "R7");
      wrr(2, 2, 32'h0008, "R5");
      wrr(2, 2, 32'h0011, "R5");
      rd(2, 2, "R5");

      // legal port and trim traffic, high-byte read
      wrr(18, 2, 32'h1200, "R11");
      rd(18, 2, "R11"); rd(19, 1, "R12"); rd(18, 1, "R11");
      wrr(12, 1, 32'h0055, "R10"); rd(12, 1, "R10");
      wrr(8, 4, 32'hABCD_E000, "R9"); rd(8, 4, "R9");

      // R1 out-of-window accesses
      acc(io_base + 16'd20, 1'b1, 2, 32'hFFFF, 1'b0, 4'h0, "R1");
      acc(io_base - 16'd2, 1'b1, 2, 32'h0000, 1'b0, 4'h0, "R1");
      rd(0, 2, "R1");
      io_base = 16'h1000;
      wrr(0, 2, 32'h0040, "R1"); rd(0, 2, "R1");
      io_base = 16'hFF40;
      rd(0, 2, "R1");

      // each rule break on its own, after a fresh reset
      do_reset(); wrr(0, 4, 32'h0002, "R3"); rd(0, 2, "R13");
      do_reset(); wrr(0, 2, 32'h0103, "R4"); rd(0, 2, "R4");
      do_reset(); wrr(4, 2, 32'h0013, "R6"); rd(4, 2, "R6");
      do_reset(); wrr(6, 2, 32'h0805, "R8"); rd(6, 2, "R8");
      do_reset(); wrr(8, 4, 32'h1234_5678, "R9"); rd(8, 4, "R9");
      do_reset(); wrr(12, 1, 32'h0085, "R10"); rd(12, 1, "R10");
      do_reset(); wrr(16, 2, 32'h1201, "R11"); rd(16, 2, "R11");
      do_reset(); wrr(17, 1, 32'h0012, "R12"); rd(16, 2, "R12");
      do_reset(); rd(16, 4, "R3");
      do_reset(); rd(17, 2, "R3");
      do_reset(); wrr(2, 2, 32'h0040, "R5");
      do_reset(); rd(17, 1, "R12"); rd(12, 1, "R3");

      // constrained random
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         logic [31:0] d;
         int off, ln;
         bit we;
         off = int'($urandom % 22);
         a   = ($urandom % 10 == 0) ? io_base - 16'(1 + $urandom % 4) : io_base + 16'(off);
         we  = $urandom % 2 == 1;
         ln  = ($urandom % 4 == 0) ? lens[$urandom % 4] : (legal(off, 2, we) ? 2 :
               (legal(off, 4, we) ? 4 : 1));
         d   = $urandom;
         if ($urandom % 2 == 0) d = d & ~rsvm(off);
         if ($urandom % 50 == 0) port_conn = 2'($urandom);
         acc(a, we, ln, d, $urandom % 3 == 0,
             ($urandom % 4 == 0) ? 4'($urandom) : 4'h0, tg(off));
         if (i == 1500) do_reset();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule